// File: doc/BRIEF.md
# PHY Link Bring-up Sequencer

This block brings an Ethernet PHY from an unknown state to a configured, negotiating link without software help. It drives a simple management request/response port: each request names a PHY address, a register number, a direction and (for writes) a data word, and the port later answers with an acknowledge pulse and, for reads, the register contents. Serialising onto the two-wire management bus is left to the port.

A start pulse runs the whole sequence. First it searches the 32 management addresses for a PHY that answers with believable identifiers. It then resets that PHY and takes a snapshot of its vendor status word (register 18), which later supplies the reported speed and duplex. Next it loads an interrupt mask, builds the advertisement word from the capability bits in the basic status register and starts autonegotiation. Waits between polls come from a millisecond prescaler and a tick counter. At the end the block pulses `done` with the address, a found flag, speed, duplex and a failed flag.

Top module: `phy_link_seq`

## Requirements
- R1: Addresses are tried from 0 upward to 31. At each address register 2 is read first and register 3 second. The scan stops at the first accepted address, so a run that accepts address A makes exactly 2*(A+1) identifier reads.
- R2: An address is accepted only when both identifier words lie strictly between 16'h0000 and 16'hFFFF and neither equals 16'h8000.
- R3: When no address is accepted, `done` pulses with `found`=0 and `failed`=1, `speed_100`=0 and `full_duplex`=0. No register is written.
- R4: After a PHY is found, register 0 is written with 16'h8000 (reset, bit 15). Register 0 is then read until bit 15 reads 0, with at most RST_POLLS (6) reads spaced one poll interval (CLKS_PER_MS*POLL_MS cycles) apart. Clearing on the last allowed read counts as success. If bit 15 never clears, the run ends with `failed`=1 and no further access.
- R5: Register 18 is read once, right after the reset clears. Its bit 7 gives `speed_100` and its bit 6 gives `full_duplex`. Both are reported at `done` even when negotiation later fails.
- R6: Before negotiation, register 19 is written with the IRQ_MASK parameter.
- R7: Register 4 is written with bit 0 set. Basic-status bits 15,14,13,12,11 are copied to advertisement bits 9,8,7,6,5, and all other bits are 0.
- R8: Register 0 is then written with 16'h1200 (enable, restart). Register 1 is polled for bit 5 (negotiation complete), at most AN_POLLS (20) reads. If bit 5 never sets, `failed`=1.
- R9: Each incomplete poll that shows bit 4 (remote fault), except the last allowed one, is followed by a write of 16'h3300 to register 0, and polling continues. A completing read that still shows bit 4 sets `failed`.
- R10: `done` is high for exactly one cycle. `found_addr` and `found` keep their values until the next start.
- R11: While reset is asserted and after it is released, all outputs are 0 and no request is issued until a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a run (ignored while busy) |
| mdio_req | output | 1 | One-cycle management request strobe |
| mdio_wr | output | 1 | Request is a write when 1 |
| mdio_phy | output | 5 | Target PHY address |
| mdio_reg | output | 5 | Target register number |
| mdio_wdata | output | 16 | Write data |
| mdio_ack | input | 1 | Request completed |
| mdio_rdata | input | 16 | Read data, valid with mdio_ack |
| done | output | 1 | One-cycle end-of-run pulse |
| found | output | 1 | A PHY was accepted |
| found_addr | output | 5 | Address of the accepted PHY |
| failed | output | 1 | Run failed (not found, reset timeout, negotiation timeout or remote fault) |
| speed_100 | output | 1 | Snapshot speed bit: 1 = 100 Mb/s |
| full_duplex | output | 1 | Snapshot duplex bit: 1 = full |

## Verification
The bench places decoy PHYs below the real one whose identifiers are 16'h8000, 16'h0000 or 16'hFFFF. A filter that is too loose stops at the decoy and reports the wrong address and identifier read count. It also makes the reset bit clear on exactly the sixth read and never. An off-by-one poll limit then shows up as a false timeout or a false success. Remote fault is injected once, on every poll, and on the completing poll. A design that miscounts retries or ignores a fault that is still present writes the wrong number of 16'h3300 words or reports success. Speed and duplex are chosen to differ from the capability bits, so taking them from the wrong word is caught.

// File: rtl/phy_link_pkg.sv
package phy_link_pkg;
  localparam logic [4:0] REG_CTRL  = 5'd0;
  localparam logic [4:0] REG_STAT  = 5'd1;
  localparam logic [4:0] REG_ID1   = 5'd2;
  localparam logic [4:0] REG_ID2   = 5'd3;
  localparam logic [4:0] REG_ADV   = 5'd4;
  localparam logic [4:0] REG_SNAP  = 5'd18;
  localparam logic [4:0] REG_IMASK = 5'd19;

  localparam logic [15:0] CTRL_RESET = 16'h8000;
  localparam logic [15:0] CTRL_ANEG  = 16'h1200;
  localparam logic [15:0] CTRL_RETRY = 16'h3300;

  localparam int CTRL_RST_BIT = 15;
  localparam int STAT_CMPL_BIT = 5;
  localparam int STAT_RFLT_BIT = 4;
  localparam int SNAP_SPD_BIT = 7;
  localparam int SNAP_DPX_BIT = 6;

  typedef enum logic [3:0] {
    S_IDLE, S_ID1, S_ID2, S_RSTW, S_RSTP, S_RWAIT, S_SNAP, S_MASK,
    S_CAPS, S_ADV, S_ANW, S_ANP, S_RFW, S_AWAIT, S_FIN
  } seq_state_t;
endpackage

// File: rtl/phy_tick_timer.sv
module phy_tick_timer #(
  parameter int CLKS_PER_MS = 200000,
  parameter int POLL_MS     = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic expired
);
  localparam int PW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
  localparam int MW = (POLL_MS > 1) ? $clog2(POLL_MS) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(CLKS_PER_MS - 1);
  localparam logic [MW-1:0] MS_LAST  = MW'(POLL_MS - 1);

  logic [PW-1:0] pre;
  logic [MW-1:0] ms;
  logic          run;

  always_ff @(posedge clk) begin
    expired <= 1'b0;
    if (rst) begin
      pre <= '0;
      ms  <= '0;
      run <= 1'b0;
    end else if (go) begin
      pre <= '0;
      ms  <= '0;
      run <= 1'b1;
    end else if (run) begin
      if (pre == PRE_LAST) begin
        pre <= '0;
        if (ms == MS_LAST) begin
          run     <= 1'b0;
          expired <= 1'b1;
        end else begin
          ms <= ms + 1'b1;
        end
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end
endmodule

// File: rtl/phy_id_filter.sv
module phy_id_filter (
  input  logic [15:0] id_hi,
  input  logic [15:0] id_lo,
  output logic        valid
);
  function automatic logic word_ok(input logic [15:0] w);
    return (w != 16'h0000) && (w != 16'hFFFF) && (w != 16'h8000);
  endfunction

  always_comb valid = word_ok(id_hi) && word_ok(id_lo);
endmodule

// File: rtl/phy_adv_map.sv
module phy_adv_map #(
  parameter int NCAP = 5
) (
  input  logic [NCAP-1:0] caps,
  output logic [15:0]     adv
);
  localparam int ADV_LSB = 5;

  for (genvar i = 0; i < 16; i++) begin : g_bit
    if (i == 0) begin : g_sel
      assign adv[i] = 1'b1;
    end else if (i >= ADV_LSB && i < ADV_LSB + NCAP) begin : g_cap
      assign adv[i] = caps[i-ADV_LSB];
    end else begin : g_zero
      assign adv[i] = 1'b0;
    end
  end
endmodule

// File: rtl/phy_link_seq.sv
module phy_link_seq
  import phy_link_pkg::*;
#(
  parameter int          CLKS_PER_MS = 200000,
  parameter int          POLL_MS     = 500,
  parameter int          RST_POLLS   = 6,
  parameter int          AN_POLLS    = 20,
  parameter logic [15:0] IRQ_MASK    = 16'hFF00
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output logic        mdio_req,
  output logic        mdio_wr,
  output logic [4:0]  mdio_phy,
  output logic [4:0]  mdio_reg,
  output logic [15:0] mdio_wdata,
  input  logic        mdio_ack,
  input  logic [15:0] mdio_rdata,
  output logic        done,
  output logic        found,
  output logic [4:0]  found_addr,
  output logic        failed,
  output logic        speed_100,
  output logic        full_duplex
);
  localparam int MAXP = (RST_POLLS > AN_POLLS) ? RST_POLLS : AN_POLLS;
  localparam int CW   = $clog2(MAXP + 1);
  localparam logic [CW-1:0] RST_LAST = CW'(RST_POLLS - 1);
  localparam logic [CW-1:0] AN_LAST  = CW'(AN_POLLS - 1);
  localparam logic [4:0]    ADDR_LAST = 5'd31;

  seq_state_t  st;
  logic        pend;
  logic [4:0]  scan;
  logic [15:0] id1_q;
  logic [15:0] adv_q;
  logic [CW-1:0] cnt;
  logic        tgo;
  logic        texp;
  logic        id_ok;
  logic [15:0] adv_w;

  logic        c_wr;
  logic [4:0]  c_reg;
  logic [15:0] c_wd;

  phy_tick_timer #(.CLKS_PER_MS(CLKS_PER_MS), .POLL_MS(POLL_MS)) u_timer (
    .clk(clk), .rst(rst), .go(tgo), .expired(texp)
  );

  phy_id_filter u_filter (.id_hi(id1_q), .id_lo(mdio_rdata), .valid(id_ok));

  phy_adv_map #(.NCAP(5)) u_adv (.caps(mdio_rdata[15:11]), .adv(adv_w));

  always_comb begin
    c_wr  = 1'b0;
    c_reg = REG_CTRL;
    c_wd  = 16'h0000;
    case (st)
      S_ID1:  c_reg = REG_ID1;
      S_ID2:  c_reg = REG_ID2;
      S_RSTW: begin c_wr = 1'b1; c_wd = CTRL_RESET; end
      S_SNAP: c_reg = REG_SNAP;
      S_MASK: begin c_wr = 1'b1; c_reg = REG_IMASK; c_wd = IRQ_MASK; end
      S_CAPS: c_reg = REG_STAT;
      S_ADV:  begin c_wr = 1'b1; c_reg = REG_ADV; c_wd = adv_q; end
      S_ANW:  begin c_wr = 1'b1; c_wd = CTRL_ANEG; end
      S_ANP:  c_reg = REG_STAT;
      S_RFW:  begin c_wr = 1'b1; c_wd = CTRL_RETRY; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; pend <= 1'b0; scan <= '0; id1_q <= '0; adv_q <= '0;
      cnt <= '0; tgo <= 1'b0;
      mdio_req <= 1'b0; mdio_wr <= 1'b0; mdio_phy <= '0; mdio_reg <= '0;
      mdio_wdata <= '0; done <= 1'b0; found <= 1'b0; found_addr <= '0;
      failed <= 1'b0; speed_100 <= 1'b0; full_duplex <= 1'b0;
    end else begin
      mdio_req <= 1'b0;
      done     <= 1'b0;
      tgo      <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          scan <= '0; found <= 1'b0; found_addr <= '0; failed <= 1'b0;
          speed_100 <= 1'b0; full_duplex <= 1'b0; st <= S_ID1;
        end
        S_RWAIT: if (texp) st <= S_RSTP;
        S_AWAIT: if (texp) st <= S_ANP;
        S_FIN: begin done <= 1'b1; st <= S_IDLE; end
        default: begin
          if (!pend) begin
            mdio_req <= 1'b1; mdio_wr <= c_wr; mdio_phy <= scan;
            mdio_reg <= c_reg; mdio_wdata <= c_wd; pend <= 1'b1;
          end else if (mdio_ack) begin
            pend <= 1'b0;
            case (st)
              S_ID1: begin id1_q <= mdio_rdata; st <= S_ID2; end
              S_ID2: begin
                if (id_ok) begin
                  found <= 1'b1; found_addr <= scan; st <= S_RSTW;
                end else if (scan == ADDR_LAST) begin
                  failed <= 1'b1; st <= S_FIN;
                end else begin
                  scan <= scan + 1'b1; st <= S_ID1;
                end
              end
              S_RSTW: begin cnt <= '0; st <= S_RSTP; end
              S_RSTP: begin
                if (!mdio_rdata[CTRL_RST_BIT]) st <= S_SNAP;
                else if (cnt == RST_LAST) begin failed <= 1'b1; st <= S_FIN; end
                else begin cnt <= cnt + 1'b1; tgo <= 1'b1; st <= S_RWAIT; end
              end
              S_SNAP: begin
                speed_100   <= mdio_rdata[SNAP_SPD_BIT];
                full_duplex <= mdio_rdata[SNAP_DPX_BIT];
                st <= S_MASK;
              end
              S_MASK: st <= S_CAPS;
              S_CAPS: begin adv_q <= adv_w; st <= S_ADV; end
              S_ADV:  st <= S_ANW;
              S_ANW:  begin cnt <= '0; st <= S_ANP; end
              S_ANP: begin
                if (mdio_rdata[STAT_CMPL_BIT]) begin
                  failed <= mdio_rdata[STAT_RFLT_BIT]; st <= S_FIN;
                end else if (cnt == AN_LAST) begin
                  failed <= 1'b1; st <= S_FIN;
                end else begin
                  cnt <= cnt + 1'b1;
                  if (mdio_rdata[STAT_RFLT_BIT]) st <= S_RFW;
                  else begin tgo <= 1'b1; st <= S_AWAIT; end
                end
              end
              S_RFW: begin tgo <= 1'b1; st <= S_AWAIT; end
              default: st <= S_IDLE;
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/phy_link_seq_chk.sv
module phy_link_seq_chk #(
  parameter logic [15:0] IRQ_MASK = 16'hFF00
) (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        mdio_req,
  input logic        mdio_wr,
  input logic [4:0]  mdio_reg,
  input logic [15:0] mdio_wdata,
  input logic        done,
  input logic        found,
  input logic [4:0]  found_addr,
  input logic        failed,
  input logic        speed_100,
  input logic        full_duplex
);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_addr_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> ($stable(found_addr) && $stable(found)));

  p_single_req_r1: assert property (@(posedge clk) disable iff (rst)
    mdio_req |=> !mdio_req);

  p_not_found_r3: assert property (@(posedge clk) disable iff (rst)
    (done && !found) |-> (failed && !speed_100 && !full_duplex));

  p_ctrl_word_r4: assert property (@(posedge clk) disable iff (rst)
    (mdio_req && mdio_wr && mdio_reg == 5'd0) |->
      (mdio_wdata == 16'h8000 || mdio_wdata == 16'h1200 || mdio_wdata == 16'h3300));

  p_mask_word_r6: assert property (@(posedge clk) disable iff (rst)
    (mdio_req && mdio_wr && mdio_reg == 5'd19) |-> (mdio_wdata == IRQ_MASK));

  p_adv_shape_r7: assert property (@(posedge clk) disable iff (rst)
    (mdio_req && mdio_wr && mdio_reg == 5'd4) |->
      (mdio_wdata[0] && mdio_wdata[15:10] == 6'd0 && mdio_wdata[4:1] == 4'd0));
endmodule

bind phy_link_seq phy_link_seq_chk #(.IRQ_MASK(IRQ_MASK)) u_chk (
  .clk(clk), .rst(rst), .start(start), .mdio_req(mdio_req), .mdio_wr(mdio_wr),
  .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata), .done(done), .found(found),
  .found_addr(found_addr), .failed(failed), .speed_100(speed_100),
  .full_duplex(full_duplex)
);

// File: tb/tb_phy_link_seq.sv
module tb_phy_link_seq;
  localparam int          CPM   = 4;
  localparam int          PMS   = 2;
  localparam int          WAITC = CPM * PMS;
  localparam logic [15:0] MASKV = 16'hA5C3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic mdio_req, mdio_wr, mdio_ack;
  logic [4:0] mdio_phy, mdio_reg, found_addr;
  logic [15:0] mdio_wdata, mdio_rdata;
  logic done, found, failed, speed_100, full_duplex;

  always #2.5 clk = ~clk;

  phy_link_seq #(.CLKS_PER_MS(CPM), .POLL_MS(PMS), .RST_POLLS(6),
                 .AN_POLLS(20), .IRQ_MASK(MASKV)) dut (
    .clk(clk), .rst(rst), .start(start), .mdio_req(mdio_req), .mdio_wr(mdio_wr),
    .mdio_phy(mdio_phy), .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata),
    .mdio_ack(mdio_ack), .mdio_rdata(mdio_rdata), .done(done), .found(found),
    .found_addr(found_addr), .failed(failed), .speed_100(speed_100),
    .full_duplex(full_duplex));

  typedef struct packed {
    logic [4:0]  m_addr;
    logic [4:0]  d_addr;
    logic [15:0] d_id1;
    logic [15:0] d_id2;
    logic [15:0] id1;
    logic [15:0] id2;
    logic [3:0]  rst_busy;
    logic [15:0] r18;
    logic [4:0]  caps;
    logic [4:0]  an_busy;
    logic [1:0]  rf;
    logic        e_found;
    logic [4:0]  e_addr;
    logic        e_fail;
    logic        e_spd;
    logic        e_dup;
    logic [15:0] e_adv;
    logic [4:0]  e_rfw;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{5'd0,  5'd0, 16'h0, 16'h0, 16'h0016, 16'hF840, 4'd0, 16'h00C0, 5'b11111, 5'd0,  2'd0, 1'b1, 5'd0,  1'b0, 1'b1, 1'b1, 16'h03E1, 5'd0},
    '{5'd5,  5'd2, 16'h8000, 16'h1234, 16'h0282, 16'h1C50, 4'd5, 16'h0080, 5'b01010, 5'd3, 2'd0, 1'b1, 5'd5, 1'b0, 1'b1, 1'b0, 16'h0141, 5'd0},
    '{5'd31, 5'd3, 16'h0000, 16'h0001, 16'h0001, 16'hFFFE, 4'd6, 16'h00C0, 5'b11111, 5'd0, 2'd0, 1'b1, 5'd31, 1'b1, 1'b0, 1'b0, 16'h0000, 5'd0},
    '{5'd9,  5'd1, 16'h1234, 16'h8000, 16'h7FFF, 16'h0002, 4'd0, 16'h0040, 5'b10001, 5'd2, 2'd2, 1'b1, 5'd9, 1'b0, 1'b0, 1'b1, 16'h0221, 5'd1},
    '{5'd12, 5'd12, 16'h0, 16'h0, 16'h1000, 16'h2000, 4'd0, 16'h0000, 5'b00100, 5'd31, 2'd1, 1'b1, 5'd12, 1'b1, 1'b0, 1'b0, 16'h0081, 5'd19},
    '{5'd20, 5'd20, 16'h0, 16'h0, 16'h0100, 16'h0200, 4'd2, 16'h0080, 5'b00000, 5'd1, 2'd1, 1'b1, 5'd20, 1'b1, 1'b1, 1'b0, 16'h0001, 5'd1},
    '{5'd1,  5'd0, 16'h1111, 16'hFFFF, 16'h0022, 16'h5555, 4'd1, 16'h00C0, 5'b11000, 5'd0, 2'd0, 1'b1, 5'd1, 1'b0, 1'b1, 1'b1, 16'h0301, 5'd0}
  };

  // PHY model configuration and observation
  vec_t cfg;
  bit   m_none;
  int   id_reads, ctrl_reads, stat_reads, writes, rfw, cyc, last_ctrl_cyc, min_gap, max_gap;
  bit   aneg_on;
  logic [15:0] last_adv, last_mask, pr;
  logic pv;

  int tests = 0;
  int fails = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    mdio_ack <= 1'b0;
    if (rst) begin
      pv <= 1'b0;
      mdio_rdata <= 16'h0;
    end else begin
      pv <= mdio_req;
      if (pv) begin mdio_ack <= 1'b1; mdio_rdata <= pr; end
      if (mdio_req) begin
        if (mdio_wr) begin
          writes = writes + 1;
          if (mdio_reg == 5'd4) last_adv = mdio_wdata;
          if (mdio_reg == 5'd19) last_mask = mdio_wdata;
          if (mdio_reg == 5'd0 && mdio_wdata == 16'h1200) aneg_on = 1'b1;
          if (mdio_reg == 5'd0 && mdio_wdata == 16'h3300) rfw = rfw + 1;
          pr <= 16'h0;
        end else begin
          case (mdio_reg)
            5'd2, 5'd3: begin
              id_reads = id_reads + 1;
              if (!m_none && mdio_phy == cfg.m_addr)
                pr <= (mdio_reg == 5'd2) ? cfg.id1 : cfg.id2;
              else if (!m_none && mdio_phy == cfg.d_addr)
                pr <= (mdio_reg == 5'd2) ? cfg.d_id1 : cfg.d_id2;
              else pr <= 16'hFFFF;
            end
            5'd0: begin
              if (ctrl_reads > 0) begin
                if (cyc - last_ctrl_cyc < min_gap) min_gap = cyc - last_ctrl_cyc;
                if (cyc - last_ctrl_cyc > max_gap) max_gap = cyc - last_ctrl_cyc;
              end
              last_ctrl_cyc = cyc;
              pr <= (ctrl_reads < int'(cfg.rst_busy)) ? 16'h8000 : 16'h0000;
              ctrl_reads = ctrl_reads + 1;
            end
            5'd1: begin
              if (!aneg_on) pr <= {cfg.caps, 11'd0};
              else begin
                stat_reads = stat_reads + 1;
                pr <= {cfg.caps, 5'd0,
                       (stat_reads > int'(cfg.an_busy)),
                       (cfg.rf == 2'd1 || (cfg.rf == 2'd2 && stat_reads == 1)),
                       4'd0};
              end
            end
            5'd18: pr <= cfg.r18;
            default: pr <= 16'h0;
          endcase
        end
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_model();
    id_reads = 0; ctrl_reads = 0; stat_reads = 0; writes = 0; rfw = 0;
    aneg_on = 1'b0; last_adv = 16'h0; last_mask = 16'h0;
    min_gap = 1000000; max_gap = 0; last_ctrl_cyc = 0;
  endtask

  // pulses start and waits for done; returns 1 on timeout
  task automatic run_once(output bit hung);
    int n;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    hung = !done;
  endtask

  initial begin
    bit hung;
    cfg = VECS[0];
    m_none = 1'b0;
    clear_model();
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 done in reset", done, 0);
    check("R11 req in reset", mdio_req, 0);
    check("R11 found/failed in reset", {found, failed, speed_100, full_duplex}, 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check("R11 idle no request", mdio_req, 0);
    check("R11 idle outputs", {done, found, found_addr, failed}, 0);

    for (int v = 0; v < NV; v++) begin
      cfg = VECS[v];
      clear_model();
      run_once(hung);
      if (hung) begin
        check("watchdog", 1, 0);
      end else begin
        check("R1 R2 found", found, cfg.e_found);
        check("R1 R2 found_addr", found_addr, cfg.e_addr);
        check("R1 id read count", id_reads, 2 * (int'(cfg.e_addr) + 1));
        check("R4 R8 R9 failed", failed, cfg.e_fail);
        check("R5 speed", speed_100, cfg.e_spd);
        check("R5 duplex", full_duplex, cfg.e_dup);
        check("R7 advertisement", last_adv, cfg.e_adv);
        check("R9 retry writes", rfw, cfg.e_rfw);
        if (cfg.e_adv != 16'h0) check("R6 mask value", last_mask, MASKV);
        if (cfg.rst_busy >= 4'd6) begin
          check("R4 reset poll count", ctrl_reads, 6);
          check("R4 no access after timeout", writes, 1);
        end
        if (cfg.rst_busy == 4'd5) begin
          check("R4 reset poll count", ctrl_reads, 6);
          check("R4 poll spacing min", (min_gap >= WAITC) ? 1 : 0, 1);
          check("R4 poll spacing max", (max_gap <= WAITC + 10) ? 1 : 0, 1);
        end
        if (cfg.an_busy == 5'd31) check("R8 neg poll count", stat_reads, 20);
        @(negedge clk);
        check("R10 done one cycle", done, 0);
        if (v == 0) begin
          repeat (20) @(negedge clk);
          check("R10 address held", found_addr, cfg.e_addr);
          check("R10 found held", found, 1);
        end
      end
    end

    // R3: no PHY on the bus
    m_none = 1'b1;
    clear_model();
    run_once(hung);
    if (hung) check("watchdog", 1, 0);
    else begin
      check("R3 not found", found, 0);
      check("R3 failed", failed, 1);
      check("R3 speed/duplex clear", {speed_100, full_duplex}, 0);
      check("R3 no writes", writes, 0);
      check("R1 full scan reads", id_reads, 64);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5ns * 190000);
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule